// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects interrupt requests from a small set of sources and presents one request line to a processor. Each source line is watched for a rising edge. An edge sets a sticky pending bit, and that bit stays set until software clears it. A per-source enable mask gates the pending bits. A fixed-priority encoder turns the surviving bits into the index of the most urgent source.

The processor sees the request only while the global interrupt enable is on. When the processor acknowledges, the block puts a vector on its data output for that same cycle. The vector is a fixed base value with the winning index in its low bits. The acknowledge also turns the global enable off at the next clock edge.

Software controls the block through single-cycle strobes:
- per-bit set and clear strobes for the mask,
- per-bit clear strobes for the pending bits,
- separate on and off commands for the global enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `int_req` and `vec_oe` are 0 and `vec_out` is zero. All mask bits are 0 (sources blocked), and the global enable is off.
- R2: A 0-to-1 change on `irq_in[i]` between two clock edges sets pending bit i at the second edge. The bit stays set after the line falls. A line that stays high after its bit is cleared does not set the bit again.
- R3: A `pend_clr[i]` strobe clears pending bit i at the next edge. If an edge on source i arrives in the same cycle, the set wins.
- R4: Mask bit value 1 lets a source through. `mask_set[i]` and `mask_clr[i]` set and clear bit i, and set wins when both are given together. A masked pending bit raises no request but stays pending, and it raises the request once the source is unmasked.
- R5: Source 0 has the highest priority and source NUM_SRC-1 the lowest. The encoded index is the lowest-numbered source that is both pending and unmasked.
- R6: The vector is VEC_BASE with its low CODE_W bits replaced by the encoded index. With the defaults the vector is 0xA0 + index.
- R7: `int_req` is 1 exactly when the global enable is on and at least one pending bit is unmasked.
- R8: `ien_on` turns the global enable on at the next edge and `ien_off` turns it off. If both are given together, off wins.
- R9: While `int_ack` and `int_req` are both 1, `vec_oe` is 1 and `vec_out` carries the vector in the same cycle. The global enable is off from the next edge, and the pending bits are not changed.
- R10: An `int_ack` while `int_req` is 0 gives `vec_oe` = 0 and leaves the global enable unchanged.
- R11: Whenever `vec_oe` is 0, `vec_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NUM_SRC | Source request lines, bit 0 most urgent |
| mask_set | input | NUM_SRC | Per-bit mask set strobe |
| mask_clr | input | NUM_SRC | Per-bit mask clear strobe |
| pend_clr | input | NUM_SRC | Per-bit pending clear strobe |
| ien_on | input | 1 | Global enable on command |
| ien_off | input | 1 | Global enable off command |
| int_ack | input | 1 | Processor acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | Vector output valid |
| vec_out | output | VEC_W | Vector address, zero when not valid |

## Verification
The assertions assume that the strobes, the acknowledge and the request lines are synchronous to `clk`. They also assume that a request line is a steady level sampled at each edge, so an edge is defined by one sample against the previous one. The bench changes every input one time unit after a rising edge and holds it for at least one whole cycle, so each edge it makes is seen exactly once. It reads the combinational vector path with a short acknowledge pulse that is removed before the next edge. Only the acknowledge tests keep `int_ack` high across an edge.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

   localparam int unsigned DEF_NUM_SRC = 4;
   localparam int unsigned DEF_VEC_W   = 8;
   localparam logic [7:0]  DEF_VEC_BASE = 8'hA0;

   // next-state choice for the global enable flop
   typedef enum logic [1:0] {
      IEN_HOLD = 2'd0,
      IEN_SET  = 2'd1,
      IEN_CLR  = 2'd2
   } ien_op_e;

endpackage

// File: rtl/irq_req_latch.sv
`timescale 1ns/1ps
module irq_req_latch #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [NUM_SRC-1:0] pend_clr,
   output logic [NUM_SRC-1:0] pend
);

   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] pend_q;

   if (NUM_SRC < 1) begin : g_bad_n
      $error("irq_req_latch: NUM_SRC must be at least 1");
   end

   // previous sample tracks the line even in reset: a level already high
   // when reset ends is not an edge
   always_ff @(posedge clk) prev_q <= irq_in;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic rise;
      assign rise = irq_in[i] & ~prev_q[i];

      always_ff @(posedge clk) begin
         if (rst)
            pend_q[i] <= 1'b0;
         else if (rise)
            pend_q[i] <= 1'b1;
         else if (pend_clr[i])
            pend_q[i] <= 1'b0;
      end

      // R2
      edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
         (irq_in[i] && !prev_q[i]) |=> pend_q[i]);

      // R3
      clr_only_chk: assert property (@(posedge clk) disable iff (rst)
         (pend_clr[i] && !(irq_in[i] && !prev_q[i])) |=> !pend_q[i]);
   end

   assign pend = pend_q;

endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] mask_set,
   input  logic [NUM_SRC-1:0] mask_clr,
   output logic [NUM_SRC-1:0] mask
);

   logic [NUM_SRC-1:0] mask_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            mask_q[i] <= 1'b0;
         else if (mask_set[i])
            mask_q[i] <= 1'b1;
         else if (mask_clr[i])
            mask_q[i] <= 1'b0;
      end

      // R4
      mask_set_chk: assert property (@(posedge clk) disable iff (rst)
         mask_set[i] |=> mask_q[i]);

      // R4
      mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
         (mask_clr[i] && !mask_set[i]) |=> !mask_q[i]);
   end

   assign mask = mask_q;

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
   parameter int unsigned NUM_SRC = 4,
   parameter bit          USE_SOP = 1'b1,
   localparam int unsigned CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [CODE_W-1:0]  code
);

   assign any = |req;

   if (NUM_SRC == 4 && USE_SOP) begin : g_sop
      // two-level form for four sources: index 0 most urgent
      logic hi_bit, lo_bit;
      assign hi_bit = ~req[0] & ~req[1];
      assign lo_bit = (~req[0] & req[1]) | (~req[0] & ~req[2]);
      assign code   = {hi_bit, lo_bit};
   end else begin : g_loop
      always_comb begin
         code = '0;
         for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (req[k]) code = CODE_W'(k);
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned          NUM_SRC  = DEF_NUM_SRC,
   parameter int unsigned          VEC_W    = DEF_VEC_W,
   parameter logic [VEC_W-1:0]     VEC_BASE = VEC_W'(DEF_VEC_BASE),
   parameter bit                   USE_SOP  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [NUM_SRC-1:0] mask_set,
   input  logic [NUM_SRC-1:0] mask_clr,
   input  logic [NUM_SRC-1:0] pend_clr,
   input  logic               ien_on,
   input  logic               ien_off,
   input  logic               int_ack,
   output logic               int_req,
   output logic               vec_oe,
   output logic [VEC_W-1:0]   vec_out
);

   localparam int unsigned CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("prio_irq_ctrl: NUM_SRC must be at least 2");
   end
   if (VEC_W <= CODE_W) begin : g_bad_vec
      $error("prio_irq_ctrl: VEC_W must exceed the code width");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] live_req;
   logic               any_live;
   logic [CODE_W-1:0]  enc_code;
   logic               ien_q;
   logic               ack_hit;
   ien_op_e            ien_op;

   irq_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
      .clk      (clk),
      .rst      (rst),
      .irq_in   (irq_in),
      .pend_clr (pend_clr),
      .pend     (pend)
   );

   irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk      (clk),
      .rst      (rst),
      .mask_set (mask_set),
      .mask_clr (mask_clr),
      .mask     (mask)
   );

   assign live_req = pend & mask;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .USE_SOP(USE_SOP)) u_enc (
      .req  (live_req),
      .any  (any_live),
      .code (enc_code)
   );

   assign int_req = ien_q & any_live;
   assign ack_hit = int_ack & int_req;

   // acknowledge beats off, off beats on
   always_comb begin
      if (ack_hit)      ien_op = IEN_CLR;
      else if (ien_off) ien_op = IEN_CLR;
      else if (ien_on)  ien_op = IEN_SET;
      else              ien_op = IEN_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ien_q <= 1'b0;
      end else begin
         case (ien_op)
            IEN_SET: ien_q <= 1'b1;
            IEN_CLR: ien_q <= 1'b0;
            default: ien_q <= ien_q;
         endcase
      end
   end

   assign vec_oe  = ack_hit;
   assign vec_out = ack_hit ? {VEC_BASE[VEC_W-1:CODE_W], enc_code} : '0;

   // R5
   enc_pick_chk: assert property (@(posedge clk) disable iff (rst)
      any_live |-> (live_req[enc_code] &&
         ((live_req & ((NUM_SRC'(1) << enc_code) - NUM_SRC'(1))) == '0)));

   // R8
   ien_off_chk: assert property (@(posedge clk) disable iff (rst)
      ien_off |=> !int_req);

   // R9
   ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (int_ack && int_req) |=> !int_req);

   // R9
   ack_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
      (int_ack && int_req && pend_clr == '0) |=> $stable(pend));

   // R11
   quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
      !vec_oe |-> (vec_out == '0));

endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] irq_in, mask_set, mask_clr, pend_clr;
   logic       ien_on, ien_off, int_ack;
   logic       int_req, vec_oe;
   logic [7:0] vec_out;
   int         total = 0;
   int         bad = 0;
   int         cyc = 0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst(rst), .irq_in(irq_in), .mask_set(mask_set),
      .mask_clr(mask_clr), .pend_clr(pend_clr), .ien_on(ien_on),
      .ien_off(ien_off), .int_ack(int_ack), .int_req(int_req),
      .vec_oe(vec_oe), .vec_out(vec_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // short acknowledge that never spans a clock edge
   task automatic peek(input string tag, input logic [7:0] exp_vec);
      int_ack = 1'b1;
      #1;
      check({tag, " oe"}, vec_oe, 1);
      check({tag, " vec"}, vec_out, exp_vec);
      int_ack = 1'b0;
      #0.5;
   endtask

   task automatic pulse_irq(input logic [3:0] v);
      irq_in = v; tick();
      irq_in = 4'b0; tick();
   endtask

   task automatic do_mask(input logic [3:0] s, input logic [3:0] c);
      mask_set = s; mask_clr = c; tick();
      mask_set = 4'b0; mask_clr = 4'b0;
   endtask

   task automatic do_ien(input logic on, input logic off);
      ien_on = on; ien_off = off; tick();
      ien_on = 1'b0; ien_off = 1'b0;
   endtask

   task automatic do_clr(input logic [3:0] c);
      pend_clr = c; tick();
      pend_clr = 4'b0;
   endtask

   task automatic cleanup();
      pend_clr = 4'hF; mask_clr = 4'hF; ien_off = 1'b1; tick();
      pend_clr = 4'b0; mask_clr = 4'b0; ien_off = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 int_req after reset", int_req, 0);
      check("R1 vec_oe after reset", vec_oe, 0);
      check("R1 vec_out after reset", vec_out, 0);
      pulse_irq(4'b0001);
      do_ien(1'b1, 1'b0);
      check("R1 mask blocks after reset", int_req, 0);
      cleanup();
   endtask

   task automatic t_edge();
      do_mask(4'hF, 4'h0);
      irq_in = 4'b0100; tick();
      check("R7 no request while enable off", int_req, 0);
      do_ien(1'b1, 1'b0);
      check("R2 edge sets pending", int_req, 1);
      peek("R2 source 2", 8'hA2);
      irq_in = 4'b0; tick();
      check("R2 pending sticky after line falls", int_req, 1);
      do_clr(4'b0100);
      check("R3 clear drops pending", int_req, 0);
      irq_in = 4'b0100; tick();
      check("R2 second edge sets again", int_req, 1);
      do_clr(4'b0100);
      tick();
      check("R2 held level no re-set", int_req, 0);
      irq_in = 4'b0; tick();
      cleanup();
   endtask

   task automatic t_setwins();
      do_mask(4'hF, 4'h0);
      do_ien(1'b1, 1'b0);
      irq_in = 4'b0010; pend_clr = 4'b0010; tick();
      irq_in = 4'b0; pend_clr = 4'b0;
      check("R3 set wins over clear", int_req, 1);
      peek("R3 source 1", 8'hA1);
      cleanup();
   endtask

   task automatic t_mask();
      do_ien(1'b1, 1'b0);
      pulse_irq(4'b1000);
      check("R4 masked source no request", int_req, 0);
      do_mask(4'b1000, 4'b0);
      check("R4 unmask raises request", int_req, 1);
      check("R11 no ack bus zero", vec_out, 0);
      peek("R4 source 3", 8'hA3);
      do_mask(4'b1000, 4'b1000);
      check("R4 mask set wins", int_req, 1);
      do_mask(4'b0, 4'b1000);
      check("R4 mask clear blocks", int_req, 0);
      do_mask(4'b1000, 4'b0);
      check("R4 pending kept while masked", int_req, 1);
      cleanup();
   endtask

   task automatic t_prio();
      do_mask(4'hF, 4'h0);
      do_ien(1'b1, 1'b0);
      pulse_irq(4'b1110);
      peek("R5 lowest index wins 1", 8'hA1);
      do_clr(4'b0010);
      peek("R5 next is 2", 8'hA2);
      do_mask(4'b0, 4'b0100);
      peek("R6 masked 2 gives 3", 8'hA3);
      pulse_irq(4'b0001);
      peek("R6 source 0 vector", 8'hA0);
      cleanup();
   endtask

   task automatic t_ien();
      do_mask(4'hF, 4'h0);
      pulse_irq(4'b0100);
      do_ien(1'b1, 1'b1);
      check("R8 off wins over on", int_req, 0);
      do_ien(1'b1, 1'b0);
      check("R8 on enables", int_req, 1);
      do_ien(1'b0, 1'b1);
      check("R8 off disables", int_req, 0);
      cleanup();
   endtask

   task automatic t_ack();
      do_mask(4'hF, 4'h0);
      pulse_irq(4'b0001);
      do_ien(1'b1, 1'b0);
      int_ack = 1'b1;
      #1;
      check("R9 ack drives oe", vec_oe, 1);
      check("R9 ack drives vector", vec_out, 8'hA0);
      tick();
      int_ack = 1'b0;
      #0.5;
      check("R9 ack clears enable", int_req, 0);
      check("R11 bus zero after ack", vec_out, 0);
      do_ien(1'b1, 1'b0);
      check("R9 pending kept after ack", int_req, 1);
      cleanup();
   endtask

   task automatic t_idle_ack();
      do_mask(4'hF, 4'h0);
      do_ien(1'b1, 1'b0);
      check("R7 no pending no request", int_req, 0);
      int_ack = 1'b1;
      #1;
      check("R10 idle ack oe low", vec_oe, 0);
      check("R11 idle ack bus zero", vec_out, 0);
      tick();
      int_ack = 1'b0;
      pulse_irq(4'b0010);
      check("R10 enable kept after idle ack", int_req, 1);
      cleanup();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      irq_in = 4'b0; mask_set = 4'b0; mask_clr = 4'b0; pend_clr = 4'b0;
      ien_on = 1'b0; ien_off = 1'b0; int_ack = 1'b0;
      repeat (3) tick();
      rst = 1'b0;
      tick();
      t_reset();
      t_edge();
      t_setwins();
      t_mask();
      t_prio();
      t_ien();
      t_ack();
      t_idle_ack();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule